// File: doc/BRIEF.md
# Bit-clearing read-only memory model with erase and identification

This block is a clocked model of a one-time programmable or ultraviolet-erasable read-only memory with 16-bit words. It is meant for testbenches and emulation platforms that need the memory's control behaviour without its analog side.

The block decodes its operating mode from four controls: chip select, output gate, program strobe and a programming-supply flag. A further flag says that a high voltage is present on address line 9. All of these controls are active low except the two flags. Data leaves the block on a 16-bit bus together with a drive flag, which replaces tri-state pins.

Programming can only clear bits, so each write stores the old word ANDed with the new data. An erase command stands in for ultraviolet exposure: it sweeps the array back to all ones at one word per clock. Reset starts the same sweep, so a freshly reset model behaves like a blank part.

All inputs are sampled on the rising edge of `clk`. The outputs are registered and reflect the inputs and array contents seen at the previous edge.

Top module: `eprom_model`

## Requirements
- R1: From reset, `busy` is high for exactly DEPTH = 2^ADDR_W clock cycles and `dout_en` is low. After that, every word reads 0xFFFF.
- R2: A read needs `ce_n`=0, `oe_n`=0 and `pgm_n`=1. One cycle after such inputs are sampled, `dout_en`=1 and `dout` holds the word stored at `addr`.
- R3: With `ce_n`=1, `dout_en` is 0 whatever `oe_n` is. Whenever `dout_en` is 0, `dout` reads 0x0000.
- R4: With `ce_n`=0, the outputs are not driven (`dout_en`=0) if `oe_n`=1 or `pgm_n`=0.
- R5: A program commits on a cycle where `pgm_n` goes from 1 to 0 while `vpp_on`=1, `ce_n`=0 and `busy`=0. The word at `addr` becomes old AND `din`, so bits are only ever cleared.
- R6: A `pgm_n` pulse while `vpp_on`=0 leaves the array unchanged.
- R7: A `pgm_n` pulse while `ce_n`=1 leaves the array unchanged.
- R8: With `vpp_on`=1, a read with `ce_n`, `oe_n` low and `pgm_n` high returns stored data, and `a9_hv` has no effect.
- R9: Identification mode needs `a9_hv`=1, `vpp_on`=0 and read controls, with every address bit other than bit 0 and bit 9 at zero. `addr[0]`=0 returns 0x0020 and `addr[0]`=1 returns 0x008C, and bits 15..8 are zero. Bit 9 is ignored.
- R10: In identification mode with any other address bit set, `dout` returns 0x0000 while driven.
- R11: An `erase_req` sampled while idle raises `busy` for exactly DEPTH cycles and leaves every word at 0xFFFF. While `busy` is high:
  - the outputs are not driven;
  - program pulses are ignored;
  - further `erase_req` pulses neither restart nor extend the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts an erase sweep |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low; the falling edge commits |
| vpp_on | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage on address line 9 (identification) |
| din | input | 16 | Data to program |
| erase_req | input | 1 | Erase command |
| dout | output | 16 | Read data, zero when not driven |
| dout_en | output | 1 | Data bus driven |
| busy | output | 1 | Erase sweep running |

## Verification
The assertions assume the following about the inputs:
- every control changes only between clock edges;
- `ce_n` is held high through reset;
- `pgm_n` is high at reset release, so the first sampled strobe is not taken as a falling edge.

The bench drives all inputs on the falling clock edge. Each program task starts with a setup cycle in which `pgm_n` is high, so every strobe is a clean 1-to-0 transition. Random traffic varies `vpp_on`, `ce_n`, `oe_n` and `a9_hv` freely, but its identification reads use small addresses often enough that both identification codes and the zero response are exercised.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] ID_CODE_LO = 16'h0020;
    localparam logic [WORD_W-1:0] ID_CODE_HI = 16'h008C;

    typedef enum logic [2:0] {
        MD_BUSY,
        MD_STBY,
        MD_HIZ,
        MD_PROG,
        MD_READ,
        MD_SIG
    } mode_e;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic  busy,
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  pgm_n,
    input  logic  vpp_on,
    input  logic  a9_hv,
    output mode_e mode
);
    always_comb begin
        if (busy) begin
            mode = MD_BUSY;
        end else if (ce_n) begin
            mode = MD_STBY;
        end else if (!pgm_n) begin
            mode = vpp_on ? MD_PROG : MD_HIZ;
        end else if (oe_n) begin
            mode = MD_HIZ;
        end else if (a9_hv && !vpp_on) begin
            mode = MD_SIG;
        end else begin
            mode = MD_READ;
        end
    end
endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic              pgm_n,
    input  mode_e             mode,
    input  logic              erase_req,
    output logic [WORD_W-1:0] rd_data,
    output logic              prog_commit,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] ptr;
        logic              pgm_q;
    } arr_st_t;

    arr_st_t           st_d, st_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;

    assign rd_data = mem[addr];

    always_comb begin
        st_d        = st_q;
        st_d.pgm_q  = pgm_n;
        wr_en       = 1'b0;
        wr_addr     = addr;
        wr_data     = rd_data & din;
        prog_commit = 1'b0;
        if (st_q.busy) begin
            wr_en    = 1'b1;
            wr_addr  = st_q.ptr;
            wr_data  = '1;
            st_d.ptr = st_q.ptr + 1'b1;
            if (st_q.ptr == LAST) begin
                st_d.busy = 1'b0;
            end
        end else if (erase_req) begin
            st_d.busy = 1'b1;
            st_d.ptr  = '0;
        end else if (mode == MD_PROG && st_q.pgm_q) begin
            wr_en       = 1'b1;
            prog_commit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b1, ptr: '0, pgm_q: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign busy = st_q.busy;

    // R11
    erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !busy) |=> busy);

    // R5
    commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_commit |-> ((wr_data & ~rd_data) == '0));
endmodule

// File: rtl/eprom_out.sv
module eprom_out
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    function automatic logic [ADDR_W-1:0] sig_mask();
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = !(i == 0 || i == 9);
        end
        return m;
    endfunction

    localparam logic [ADDR_W-1:0] SIG_MASK = sig_mask();

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    sig_ok;

    always_comb begin
        sig_ok  = ((addr & SIG_MASK) == '0);
        st_d    = '{en: 1'b0, data: '0};
        case (mode)
            MD_READ: begin
                st_d.en   = 1'b1;
                st_d.data = rd_data;
            end
            MD_SIG: begin
                st_d.en = 1'b1;
                if (sig_ok) begin
                    st_d.data = addr[0] ? ID_CODE_HI : ID_CODE_LO;
                end
            end
            default: st_d = '{en: 1'b0, data: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.data;
    assign dout_en = st_q.en;

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));
endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_on,
    input  logic              a9_hv,
    input  logic [WORD_W-1:0] din,
    input  logic              erase_req,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    mode_e             mode;
    logic [WORD_W-1:0] rd_data;
    logic              prog_commit;

    eprom_mode_dec u_dec (
        .busy   (busy),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_on (vpp_on),
        .a9_hv  (a9_hv),
        .mode   (mode)
    );

    eprom_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .din         (din),
        .pgm_n       (pgm_n),
        .mode        (mode),
        .erase_req   (erase_req),
        .rd_data     (rd_data),
        .prog_commit (prog_commit),
        .busy        (busy)
    );

    eprom_out #(.ADDR_W(ADDR_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .addr    (addr),
        .rd_data (rd_data),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ce_n));

    // R4
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!oe_n && pgm_n));

    // R7
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_commit |-> (!ce_n && vpp_on && !pgm_n && $past(pgm_n)));

    // R9
    sig_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(a9_hv && !vpp_on)) |-> (dout[15:8] == 8'h00));

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !dout_en);
endmodule

// File: tb/eprom_model_bench.sv
`timescale 1ns/1ps
module eprom_model_bench;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, oe_n, pgm_n, vpp_on, a9_hv, erase_req;
    logic [15:0]   din;
    logic [15:0]   dout;
    logic          dout_en, busy;

    int          tests = 0;
    int          fails = 0;
    logic [15:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    eprom_model #(.ADDR_W(AW)) u_eprom_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .vpp_on(vpp_on), .a9_hv(a9_hv), .din(din),
        .erase_req(erase_req), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic vpp, input logic a9);
        logic other_zero;
        other_zero = 1'b1;
        for (int i = 1; i < AW; i++) begin
            if (i != 9 && a[i]) other_zero = 1'b0;
        end
        if (a9 && !vpp) begin
            if (!other_zero) return 16'h0000;
            return a[0] ? 16'h008C : 16'h0020;
        end
        return exp_mem[a];
    endfunction

    task automatic rd(input logic [AW-1:0] a, input logic ce, input logic oe,
                      input logic vpp, input logic a9, input string tag);
        logic        en_x;
        logic [15:0] d_x;
        @(negedge clk);
        addr = a; ce_n = ce; oe_n = oe; pgm_n = 1'b1; vpp_on = vpp; a9_hv = a9;
        @(negedge clk);
        en_x = !ce && !oe;
        d_x  = en_x ? exp_read(a, vpp, a9) : 16'h0000;
        chk(dout_en == en_x, {tag, " en"}, 32'(dout_en), 32'(en_x));
        chk(dout == d_x, {tag, " data"}, 32'(dout), 32'(d_x));
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [15:0] d,
                        input logic vpp, input logic ce);
        @(negedge clk);
        addr = a; din = d; ce_n = ce; oe_n = 1'b0; pgm_n = 1'b1; vpp_on = vpp; a9_hv = 1'b0;
        @(negedge clk);
        pgm_n = 1'b0;
        @(negedge clk);
        chk(dout_en == 1'b0, "R4 strobe low quiet", 32'(dout_en), 0);
        pgm_n = 1'b1;
        if (vpp && !ce) exp_mem[a] = exp_mem[a] & d;
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_on = 1'b0; a9_hv = 1'b0;
        erase_req = 1'b0; din = 16'h0; addr = '0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int  cnt;
        bit  quiet;
        void'($urandom(32'd4242));
        idle();
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        chk(dout_en == 1'b0, "R1 reset quiet", 32'(dout_en), 0);
        rst_n = 1'b1;
        cnt = 0;
        while (busy && cnt < DEPTH + 10) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == DEPTH, "R1 reset sweep length", cnt, DEPTH);

        for (int i = 0; i < DEPTH; i++) rd(AW'(i), 1'b0, 1'b0, 1'b0, 1'b0, "R1 blank word");

        prog(AW'(5), 16'hA5F0, 1'b1, 1'b0);
        rd(AW'(5), 1'b0, 1'b0, 1'b0, 1'b0, "R2 read programmed");
        prog(AW'(5), 16'h0FFF, 1'b1, 1'b0);
        rd(AW'(5), 1'b0, 1'b0, 1'b0, 1'b0, "R5 and-write");
        chk(dout == 16'h05F0, "R5 and-write value", 32'(dout), 32'h05F0);

        prog(AW'(6), 16'h0000, 1'b0, 1'b0);
        rd(AW'(6), 1'b0, 1'b0, 1'b0, 1'b0, "R6 no supply");
        chk(dout == 16'hFFFF, "R6 word unchanged", 32'(dout), 32'hFFFF);
        prog(AW'(7), 16'h0000, 1'b1, 1'b1);
        rd(AW'(7), 1'b0, 1'b0, 1'b0, 1'b0, "R7 inhibit");
        chk(dout == 16'hFFFF, "R7 word unchanged", 32'(dout), 32'hFFFF);

        rd(AW'(5), 1'b1, 1'b0, 1'b0, 1'b0, "R3 standby gate low");
        rd(AW'(5), 1'b1, 1'b1, 1'b0, 1'b0, "R3 standby gate high");
        rd(AW'(5), 1'b0, 1'b1, 1'b0, 1'b0, "R4 gate high");

        rd(AW'(5), 1'b0, 1'b0, 1'b1, 1'b1, "R8 verify a9 ignored");
        chk(dout == 16'h05F0, "R8 verify value", 32'(dout), 32'h05F0);

        rd(AW'(0), 1'b0, 1'b0, 1'b0, 1'b1, "R9 id low");
        chk(dout == 16'h0020, "R9 id low value", 32'(dout), 32'h0020);
        rd(AW'(1), 1'b0, 1'b0, 1'b0, 1'b1, "R9 id high");
        chk(dout == 16'h008C, "R9 id high value", 32'(dout), 32'h008C);
        rd(AW'(10'h201), 1'b0, 1'b0, 1'b0, 1'b1, "R9 bit9 ignored");
        rd(AW'(2), 1'b0, 1'b0, 1'b0, 1'b1, "R10 stray line");
        chk(dout == 16'h0000, "R10 stray value", 32'(dout), 0);
        rd(AW'(10'h081), 1'b0, 1'b0, 1'b0, 1'b1, "R10 stray high line");

        for (int k = 0; k < 600; k++) begin
            int unsigned op;
            logic [AW-1:0] ra;
            op = $urandom % 4;
            ra = AW'($urandom);
            if (op == 0) begin
                prog(ra, 16'($urandom), ($urandom % 4) != 0, ($urandom % 4) == 0);
            end else if (op == 1) begin
                if ($urandom % 2) ra = AW'($urandom % 4);
                rd(ra, 1'b0, 1'b0, 1'b0, 1'b1, "R9 R10 random id");
            end else begin
                rd(ra, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
                   ($urandom % 3) == 0, "R2 R8 random read");
            end
        end

        @(negedge clk);
        idle();
        erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0;
        cnt = 0;
        quiet = 1'b1;
        while (busy && cnt < DEPTH + 10) begin
            cnt++;
            if (cnt > 2 && dout_en) quiet = 1'b0;
            if (cnt == 5) begin
                erase_req = 1'b1; vpp_on = 1'b1; addr = AW'(3); din = 16'h0000; pgm_n = 1'b0;
            end else if (cnt == 6) begin
                erase_req = 1'b0; pgm_n = 1'b1; vpp_on = 1'b0;
            end
            @(negedge clk);
        end
        chk(cnt == DEPTH, "R11 sweep length", cnt, DEPTH);
        chk(quiet, "R11 quiet while busy", 32'(quiet), 1);
        idle();
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'hFFFF;
        for (int i = 0; i < DEPTH; i++) rd(AW'(i), 1'b0, 1'b0, 1'b0, 1'b0, "R11 erased word");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule